// File: doc/BRIEF.md
# Serial EEPROM Byte Master

This block drives a two-wire serial EEPROM bus as the only master on it. It carries out three kinds of transfer: a single-byte write, a single-byte random read, and a poll that waits until the memory has finished its internal write cycle. A 9-bit byte address is split in two. The low eight bits travel as an address byte, and the bits above them are folded into the device-select byte. This lets a 512-byte device be reached without a second address byte.

The host places an operation code, an address and a write byte on the command port and pulses `cmd_valid` while `busy` is low. The block then sequences START, byte, acknowledge and STOP conditions on the open-drain lines. When the transfer ends it pulses `done` for one cycle, together with an error flag and, for a read, the fetched byte. Bus timing comes from a parameterised divider that splits each SCL period into four equal phases.

Top module: `eeprom_byte_master`

## Requirements
- R1: After reset and whenever the block is idle, `busy`, `done`, `scl_oe` and `sda_oe` are low, so both bus lines are released. `ack_err` and `rdata` reset to zero.
- R2: The select byte is 0xA0 with address bit 8 placed at bit 1 and the direction in bit 0 (0 = write, 1 = read). Address 0x1xx therefore selects with 0xA2 for a write and 0xA3 for a read.
- R3: Operation code 0 (write) sends START, select (write), low address, data, then STOP. The byte lands at the 9-bit address, and the transfer contains exactly one START.
- R4: Operation code 1 (read) sends START, select (write), low address, a repeated START, select (read), then eight clocks in, and returns that byte on `rdata` when `done` pulses. The transfer contains exactly two STARTs.
- R5: Every byte is shifted most significant bit first, with eight data clocks followed by one acknowledge clock. In data and acknowledge slots, SDA changes only while SCL is low.
- R6: After the eight data bits of a read, the master leaves SDA high for one clock (no acknowledge) before STOP.
- R7: Operation code 2 (poll) repeats START plus select 0xA0 until the device acknowledges, then issues STOP and completes with `ack_err` low.
- R8: If the select, address or data byte of a read or write is not acknowledged, the block issues STOP, returns to idle and reports `ack_err` high with `done`. The memory is left unwritten.
- R9: While `busy` is high, `cmd_valid` is ignored. The command in progress keeps its address and data, and no second transfer follows.
- R10: Operation code 3 is ignored. `busy` stays low and no START appears on the bus.
- R11: `done` is a one-cycle pulse issued once per accepted command as `busy` falls, and `ack_err` changes only in that cycle.
- R12: One SCL period lasts 4 × (CLK_HZ / (4 × SCL_HZ)) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 0 write, 1 read, 2 poll, 3 ignored |
| cmd_addr | input | 9 | Byte address; bit 8 goes into the select byte |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Last transfer missed an acknowledge |
| rdata | output | 8 | Byte returned by the last read |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The hardest cases to reach are those where the device refuses the master: a select byte rejected because an internal write is still running, and a rejection in the middle of a transfer at the address byte. A behavioural memory model on the wired bus rejects a fixed number of select bytes after each stored write, so a poll issued straight after a write has to loop through several STARTs before it is acknowledged. The bench can also force a reject of the address byte or keep the device busy indefinitely, which drives the error path. Counts of START and STOP conditions and a log of select bytes confirm the framing from outside the block.

// File: rtl/eebm_pkg.sv
`timescale 1ns/1ps
package eebm_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_POLL  = 2'd2,
    OP_NONE  = 2'd3
  } eebm_op_e;

  typedef enum logic [1:0] {
    BK_START = 2'd0,
    BK_STOP  = 2'd1,
    BK_BIT   = 2'd2
  } eebm_bk_e;

  localparam logic [3:0] SEL_TYPE = 4'b1010;
endpackage

// File: rtl/eebm_tick.sv
`timescale 1ns/1ps
module eebm_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R12
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/eebm_bitio.sv
`timescale 1ns/1ps
module eebm_bitio
  import eebm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     req,
  input  eebm_bk_e kind,
  input  logic     tx_bit,
  input  logic     sda_i,
  output logic     fin,
  output logic     rx_bit,
  output logic     scl_oe,
  output logic     sda_oe
);
  logic     act_q, act_d;
  eebm_bk_e kind_q, kind_d;
  logic     tx_q, tx_d;
  logic [1:0] ph_q, ph_d;
  logic     rx_q, rx_d;
  logic     scl_q, scl_d;
  logic     sda_q, sda_d;
  logic     fin_q, fin_d;

  always_comb begin
    act_d  = act_q;
    kind_d = kind_q;
    tx_d   = tx_q;
    ph_d   = ph_q;
    rx_d   = rx_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    fin_d  = 1'b0;
    if (!act_q) begin
      if (req) begin
        act_d  = 1'b1;
        kind_d = kind;
        tx_d   = tx_bit;
        ph_d   = 2'd0;
      end
    end else if (tick) begin
      ph_d = ph_q + 2'd1;
      unique case (kind_q)
        BK_START: begin
          unique case (ph_q)
            2'd0: begin scl_d = 1'b1; sda_d = 1'b0; end
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            2'd3: scl_d = 1'b1;
          endcase
        end
        BK_STOP: begin
          unique case (ph_q)
            2'd0: begin scl_d = 1'b1; sda_d = 1'b1; end
            2'd1: scl_d = 1'b0;
            2'd2: ;
            2'd3: sda_d = 1'b0;
          endcase
        end
        default: begin
          unique case (ph_q)
            2'd0: begin scl_d = 1'b1; sda_d = !tx_q; end
            2'd1: scl_d = 1'b0;
            2'd2: rx_d = sda_i;
            2'd3: scl_d = 1'b1;
          endcase
        end
      endcase
      if (ph_q == 2'd3) begin
        act_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      kind_q <= BK_BIT;
      tx_q   <= 1'b1;
      ph_q   <= 2'd0;
      rx_q   <= 1'b1;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      kind_q <= kind_d;
      tx_q   <= tx_d;
      ph_q   <= ph_d;
      rx_q   <= rx_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      fin_q  <= fin_d;
    end
  end

  assign fin    = fin_q;
  assign rx_bit = rx_q;
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && kind_q == BK_BIT && !scl_q && $past(!scl_q)) |-> $stable(sda_q));
endmodule

// File: rtl/eebm_seq.sv
`timescale 1ns/1ps
module eebm_seq
  import eebm_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              bit_fin,
  input  logic              bit_rx,
  output logic              bit_req,
  output eebm_bk_e          bit_kind,
  output logic              bit_tx,
  output logic              busy,
  output logic              done,
  output logic              ack_err,
  output logic [7:0]        rdata
);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SEL, ST_LO, ST_WD,
    ST_RSTART, ST_SELR, ST_RD, ST_STOP
  } st_e;

  st_e               st_q, st_d;
  eebm_op_e          op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wd_q, wd_d;
  logic [7:0]        sh_q, sh_d;
  logic [3:0]        cnt_q, cnt_d;
  logic              iss_q, iss_d;
  logic              err_q, err_d;
  logic              aerr_q, aerr_d;
  logic [7:0]        rd_q, rd_d;
  logic              done_q, done_d;
  logic              is_tx;
  logic [2:0]        hi3;
  logic [7:0]        sel_w, sel_r;

  always_comb begin
    hi3   = (op_q == OP_POLL) ? 3'd0 : 3'(addr_q[ADDR_W-1:ADDR_W-HI_W]);
    sel_w = {SEL_TYPE, hi3, 1'b0};
    sel_r = {SEL_TYPE, hi3, 1'b1};
    is_tx = (st_q == ST_SEL) || (st_q == ST_LO) || (st_q == ST_WD) || (st_q == ST_SELR);
  end

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    iss_d    = iss_q;
    err_d    = err_q;
    aerr_d   = aerr_q;
    rd_d     = rd_q;
    done_d   = 1'b0;
    bit_req  = 1'b0;
    bit_kind = BK_BIT;
    bit_tx   = 1'b1;

    if (st_q != ST_IDLE && !iss_q) begin
      bit_req = 1'b1;
      iss_d   = 1'b1;
      if (st_q == ST_START || st_q == ST_RSTART) bit_kind = BK_START;
      else if (st_q == ST_STOP)                  bit_kind = BK_STOP;
      if (is_tx && cnt_q != 4'd8) bit_tx = sh_q[7];
    end

    if (st_q == ST_IDLE) begin
      if (cmd_valid && eebm_op_e'(cmd_op) != OP_NONE) begin
        op_d   = eebm_op_e'(cmd_op);
        addr_d = cmd_addr;
        wd_d   = cmd_wdata;
        err_d  = 1'b0;
        cnt_d  = 4'd0;
        st_d   = ST_START;
      end
    end else if (bit_fin) begin
      iss_d = 1'b0;
      if ((is_tx || st_q == ST_RD) && cnt_q != 4'd8) begin
        cnt_d = cnt_q + 4'd1;
        sh_d  = is_tx ? {sh_q[6:0], 1'b0} : {sh_q[6:0], bit_rx};
      end else begin
        cnt_d = 4'd0;
        unique case (st_q)
          ST_START:  begin st_d = ST_SEL;  sh_d = sel_w; end
          ST_RSTART: begin st_d = ST_SELR; sh_d = sel_r; end
          ST_SEL: begin
            if (op_q == OP_POLL) st_d = bit_rx ? ST_START : ST_STOP;
            else if (bit_rx) begin err_d = 1'b1; st_d = ST_STOP; end
            else begin st_d = ST_LO; sh_d = addr_q[7:0]; end
          end
          ST_LO: begin
            if (bit_rx) begin err_d = 1'b1; st_d = ST_STOP; end
            else if (op_q == OP_WRITE) begin st_d = ST_WD; sh_d = wd_q; end
            else st_d = ST_RSTART;
          end
          ST_WD: begin err_d = bit_rx; st_d = ST_STOP; end
          ST_SELR: begin
            if (bit_rx) begin err_d = 1'b1; st_d = ST_STOP; end
            else st_d = ST_RD;
          end
          ST_RD: begin rd_d = sh_q; st_d = ST_STOP; end
          ST_STOP: begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            aerr_d = err_q;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_WRITE;
      addr_q <= '0;
      wd_q   <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      iss_q  <= 1'b0;
      err_q  <= 1'b0;
      aerr_q <= 1'b0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      iss_q  <= iss_d;
      err_q  <= err_d;
      aerr_q <= aerr_d;
      rd_q   <= rd_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign ack_err = aerr_q;
  assign rdata   = rd_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11
  err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aerr_q) |-> done_q);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(addr_q) && $stable(wd_q)));
  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8);
endmodule

// File: rtl/eeprom_byte_master.sv
`timescale 1ns/1ps
module eeprom_byte_master
  import eebm_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCL_HZ = 100_000,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              ack_err,
  output logic [7:0]        rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_i
);
  localparam int DIV = CLK_HZ / (4 * SCL_HZ);

  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       tick, bit_req, bit_tx, bit_fin, bit_rx;
  eebm_bk_e   bit_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  eebm_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .en(busy), .tick(tick)
  );

  eebm_bitio u_bitio (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .req(bit_req),
    .kind(bit_kind), .tx_bit(bit_tx), .sda_i(sda_i), .fin(bit_fin),
    .rx_bit(bit_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  eebm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bit_fin(bit_fin),
    .bit_rx(bit_rx), .bit_req(bit_req), .bit_kind(bit_kind), .bit_tx(bit_tx),
    .busy(busy), .done(done), .ack_err(ack_err), .rdata(rdata)
  );

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_eeprom_byte_master.sv
`timescale 1ns/1ps
module sim_eeprom_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;
  localparam int BUSY_N = 3;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, sda_i;
  logic [1:0] cmd_op;
  logic [8:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic busy, done, ack_err, scl_oe, sda_oe;
  logic [7:0] rdata;

  always #(CLK_PERIOD/2) clk = !clk;

  eeprom_byte_master #(.CLK_HZ(4_000_000), .SCL_HZ(100_000), .ADDR_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .ack_err(ack_err), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_i(sda_i)
  );

  // ---------------- memory model on the wired bus ----------------
  logic s_pull = 1'b0;
  logic scl_w, sda_w;
  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || s_pull);
  assign sda_i = sda_w;

  logic [7:0] mem [512];
  logic [7:0] sel_log [256];
  int   n_sel = 0, n_start = 0, n_stop = 0, wbusy = 0;
  int   cnt = 0, bidx = 0;
  bit   s_act = 0, ackdrv = 0, rd_mode = 0, rd_started = 0, wrote = 0, nack_lo = 0;
  logic [7:0] sh = 8'h00, outb = 8'h00, ptr_lo = 8'h00;
  logic hi = 1'b0, m_nack = 1'b0;
  time  t_prev = 0, t_last = 0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    n_start++; s_act = 1; cnt = 0; bidx = 0; ackdrv = 0;
    rd_mode = 0; rd_started = 0; s_pull = 0;
  end

  always @(posedge sda_w) if (scl_w === 1'b1) begin
    n_stop++; s_act = 0; s_pull = 0;
    if (wrote) wbusy = BUSY_N;
    wrote = 0;
  end

  always @(posedge scl_w) begin
    t_prev = t_last; t_last = $time;
    if (s_act) begin
      if (!ackdrv) begin
        if (!rd_mode) sh = {sh[6:0], sda_w};
        if (cnt < 8) cnt++;
      end else if (rd_mode) m_nack = sda_w;
    end
  end

  always @(negedge scl_w) if (s_act) begin
    if (ackdrv) begin
      ackdrv = 0; cnt = 0; s_pull = 0;
      if (rd_mode) begin
        if (rd_started) s_act = 0;
        else begin rd_started = 1; s_pull = !outb[7]; end
      end
    end else if (cnt == 8) begin
      ackdrv = 1;
      if (rd_mode && rd_started) s_pull = 0;
      else begin
        if (bidx == 0) begin
          sel_log[n_sel[7:0]] = sh; n_sel++;
          if (sh[7:4] == 4'hA && sh[3:2] == 2'b00 && wbusy == 0) begin
            s_pull = 1; hi = sh[1];
            if (sh[0]) begin rd_mode = 1; outb = mem[{sh[1], ptr_lo}]; end
          end else begin
            if (wbusy > 0) wbusy--;
            s_pull = 0; s_act = 0;
          end
        end else if (bidx == 1) begin
          if (nack_lo) begin s_pull = 0; s_act = 0; end
          else begin ptr_lo = sh; s_pull = 1; end
        end else if (bidx == 2) begin
          mem[{hi, ptr_lo}] = sh; wrote = 1; s_pull = 1;
        end else s_pull = 1;
        bidx++;
      end
    end else if (rd_mode && rd_started) s_pull = !outb[7-cnt];
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string      rq;
    logic       err;
    logic [7:0] rd;
    bit         chk_rd;
  } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, dbl_done = 0;
  bit prev_done = 0, finished = 0;

  task automatic check(input string rq, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (prev_done) dbl_done++;
      if (exp_q.size() == 0) check("R11", 1, 0, "done without command");
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.rq, int'(ack_err), int'(e.err), "ack_err at done");
        if (e.chk_rd) check(e.rq, int'(rdata), int'(e.rd), "rdata at done");
      end
    end
    prev_done = done;
  end

  task automatic run_cmd(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d,
                         input logic e_err, input logic [7:0] e_rd, input bit e_chk,
                         input string rq);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back('{rq: rq, err: e_err, rd: e_rd, chk_rd: e_chk});
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, p0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", busy, 0, "busy after reset");
    check("R1", done, 0, "done after reset");
    check("R1", scl_oe, 0, "scl_oe after reset");
    check("R1", sda_oe, 0, "sda_oe after reset");
    check("R1", ack_err, 0, "ack_err after reset");
    check("R1", rdata, 0, "rdata after reset");

    // R3 write low half
    s0 = n_start; p0 = n_stop;
    run_cmd(2'd0, 9'h005, 8'h3C, 1'b0, 8'h00, 0, "R3");
    check("R3", mem[9'h005], 8'h3C, "stored byte");
    check("R3", n_start - s0, 1, "START count in write");
    check("R3", n_stop - p0, 1, "STOP count in write");
    check("R2", sel_log[n_sel-1], 8'hA0, "write select low page");
    wbusy = 0;

    // R2 / R5 write high half, then R7 poll through the busy window
    run_cmd(2'd0, 9'h1A7, 8'h81, 1'b0, 8'h00, 0, "R3");
    check("R5", mem[9'h1A7], 8'h81, "MSB-first stored byte");
    check("R2", sel_log[n_sel-1], 8'hA2, "write select high page");
    s0 = n_start; p0 = n_stop;
    run_cmd(2'd2, 9'h1A7, 8'h00, 1'b0, 8'h00, 0, "R7");
    check("R7", n_start - s0, BUSY_N + 1, "START repeats while busy");
    check("R7", n_stop - p0, 1, "single STOP after poll");
    for (int k = 1; k <= BUSY_N + 1; k++)
      check("R7", sel_log[n_sel-k], 8'hA0, "poll select byte");

    // R4 random reads, R6 trailing NACK, R12 SCL period
    s0 = n_start;
    run_cmd(2'd1, 9'h005, 8'h00, 1'b0, 8'h3C, 1, "R4");
    check("R4", n_start - s0, 2, "START count in read");
    check("R6", m_nack, 1, "master NACK after data");
    check("R12", int'(t_last - t_prev), 4 * DIV * CLK_PERIOD, "SCL period ns");
    m_nack = 1'b0;
    run_cmd(2'd1, 9'h1A7, 8'h00, 1'b0, 8'h81, 1, "R4");
    check("R2", sel_log[n_sel-2], 8'hA2, "dummy write select");
    check("R2", sel_log[n_sel-1], 8'hA3, "read select high page");
    check("R6", m_nack, 1, "master NACK second read");

    // R5 pattern on address 0x0FF must not touch 0x1FF
    run_cmd(2'd0, 9'h0FF, 8'hE7, 1'b0, 8'h00, 0, "R5");
    wbusy = 0;
    check("R5", mem[9'h1FF], 8'h00, "other page untouched");
    run_cmd(2'd1, 9'h0FF, 8'h00, 1'b0, 8'hE7, 1, "R5");

    // R8 address byte refused
    nack_lo = 1; p0 = n_stop;
    run_cmd(2'd0, 9'h030, 8'h99, 1'b1, 8'h00, 0, "R8");
    nack_lo = 0;
    check("R8", mem[9'h030], 8'h00, "no store after address NACK");
    check("R8", n_stop - p0, 1, "STOP after address NACK");
    check("R1", {scl_oe, sda_oe}, 0, "bus released after error");
    // R8 select refused while device busy
    wbusy = 1000;
    run_cmd(2'd1, 9'h005, 8'h00, 1'b1, 8'h00, 0, "R8");
    wbusy = 0;
    run_cmd(2'd0, 9'h031, 8'h42, 1'b0, 8'h00, 0, "R8");
    wbusy = 0;
    check("R8", mem[9'h031], 8'h42, "recovery after error");

    // R9 command during busy is ignored
    @(negedge clk);
    exp_q.push_back('{rq: "R9", err: 1'b0, rd: 8'h00, chk_rd: 0});
    cmd_op = 2'd0; cmd_addr = 9'h010; cmd_wdata = 8'h55; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    cmd_op = 2'd0; cmd_addr = 9'h020; cmd_wdata = 8'h77; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2000) @(negedge clk);
    wbusy = 0;
    check("R9", busy, 0, "no second transfer");
    check("R9", mem[9'h010], 8'h55, "first command kept");
    check("R9", mem[9'h020], 8'h00, "overlapping command dropped");

    // R10 reserved operation code
    s0 = n_start;
    cmd_op = 2'd3; cmd_addr = 9'h040; cmd_wdata = 8'h11; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10", busy, 0, "busy after code 3");
    repeat (200) @(negedge clk);
    check("R10", n_start - s0, 0, "START after code 3");

    // R11 pulse shape and pairing
    check("R11", dbl_done, 0, "done longer than one cycle");
    check("R11", exp_q.size(), 0, "commands left without done");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule